// File: doc/BRIEF.md
# Unrolled Backward State-Metric Chain for an 8-State Max-Log Decoder

This block computes the backward state metrics of a sliding decoding window for an 8-state recursive systematic convolutional code. The usual backward recursion uses a feedback loop. Here it is unrolled into a chain of identical feed-forward stages. Each stage takes the eight metrics of trellis step k+1 and the four branch metrics of step k. It produces the eight metrics of step k through one register stage. Because the chain holds no feedback, a new window can enter on every clock cycle, and many windows can be in flight down the chain at once.

Each stage holds eight add-compare-select units, one per trellis state. Each stage also holds a one-cycle buffer on its own branch metrics, so those metrics arrive together with the metric vector coming from the stage before. Every stage normalizes its result against the state-0 metric of its own input vector, which keeps the values bounded along the chain. The chain entry loads either a supplied boundary vector or an all-zero vector. The all-zero vector is used when the state at the window end is not known.

The branch metrics reach the chain skewed in time. The four values for stage j of a window are presented j cycles after that window enters. This matches branch metrics that stream in one trellis step per cycle.

Top module: `bmsChain`

## Requirements
- R1: Trellis: state s = {s[2],s[1],s[0]} with input bit u gives feedback a = u^s[1]^s[2], parity p = a^s[0]^s[2] and successor {s[1],s[0],a}. The new metric of s is the larger (signed) of metric(successor(s,0)) + gamma(s,0) and metric(successor(s,1)) + gamma(s,1).
- R2: Each stage subtracts the state-0 metric of its input vector from all eight results. All metric arithmetic is two's complement modulo 2^W, with W = 12 by default.
- R3: A window captured with inValid at clock edge e reaches betaOut, with outValid high, at edge e+NSTAGES. Its stage-j branch metrics must be presented in the cycle captured at edge e+j.
- R4: When boundaryKnown is 0 for an accepted window, the chain starts from all-zero metrics, and betaBoundary has no effect on that window's result.
- R5: Windows may enter on consecutive cycles. Each accepted window gives exactly one outValid cycle, in order, with no interference between windows.
- R6: While outValid is low, betaOut holds the last result it presented. Branch metrics and boundary values on cycles without a window do not alter any result.
- R7: After reset, outValid is 0 and betaOut is all zeros.
- R8: Branch metric for input u and parity p sits in slot 2u+p, bits [(2u+p)*BW +: BW], of a stage's 4*BW field. Stage j uses field [j*4*BW +: 4*BW] of gammaBus. Values are signed and sign-extended to W bits. State s of a metric vector is bits [s*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A new window enters the chain this cycle |
| boundaryKnown | input | 1 | 1: start from betaBoundary, 0: start from zeros |
| betaBoundary | input | 8*W | Metric vector at the window end |
| gammaBus | input | NSTAGES*4*BW | Skewed per-stage branch metrics |
| outValid | output | 1 | betaOut holds a finished window |
| betaOut | output | 8*W | Normalized metrics after the last stage |

## Verification
A window captured at edge e is due on the outputs at edge e+NSTAGES. The bench therefore keeps a cycle index and drives the branch metrics of window w for stage j in cycle w+j. At each falling edge of cycle c it compares the outputs against window c-1-NSTAGES, before it drives the inputs of cycle c. Empty slots between windows are filled with unrelated metric values. In those cycles the bench expects outValid low and betaOut unchanged.

// File: rtl/bmsPkg.sv
package bmsPkg;

  localparam int NUM_STATES = 8;
  localparam int NUM_LABELS = 4;

  typedef struct packed {
    logic loadIn;
    logic zeroStart;
  } bmsStrobes_t;

  // feedback bit entering the shift register for state s and input u
  function automatic int feedBit(int s, int u);
    return (u ^ (s >> 1) ^ (s >> 2)) & 1;
  endfunction

  function automatic int nextState(int s, int u);
    return ((s & 3) << 1) | feedBit(s, u);
  endfunction

  // slot of the branch metric: 2*u + parity
  function automatic int branchLabel(int s, int u);
    int p;
    p = (feedBit(s, u) ^ s ^ (s >> 2)) & 1;
    return 2 * u + p;
  endfunction

endpackage

// File: rtl/bmsAcs.sv
module bmsAcs #(
  parameter int W = 12
) (
  input  logic [W-1:0] metricA,
  input  logic [W-1:0] metricB,
  input  logic [W-1:0] gammaA,
  input  logic [W-1:0] gammaB,
  input  logic [W-1:0] normRef,
  output logic [W-1:0] result
);
  logic [W-1:0] sumA;
  logic [W-1:0] sumB;
  logic         pickB;

  always_comb begin
    sumA   = metricA + gammaA;
    sumB   = metricB + gammaB;
    pickB  = $signed(sumB) > $signed(sumA);
    result = (pickB ? sumB : sumA) - normRef;
  end
endmodule

// File: rtl/bmsStage.sv
module bmsStage #(
  parameter int W  = 12,
  parameter int BW = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                en,
  input  logic [bmsPkg::NUM_LABELS*BW-1:0]    gammaIn,
  input  logic [bmsPkg::NUM_STATES*W-1:0]     betaIn,
  output logic [bmsPkg::NUM_STATES*W-1:0]     betaOut
);
  localparam int NS = bmsPkg::NUM_STATES;
  localparam int NL = bmsPkg::NUM_LABELS;

  logic [NL*BW-1:0] gammaBuf;
  logic [NL*W-1:0]  gammaExt;
  logic [NS*W-1:0]  acsOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gammaBuf <= '0;
    else       gammaBuf <= gammaIn;
  end

  for (genvar l = 0; l < NL; l++) begin : g_ext
    assign gammaExt[l*W +: W] = {{(W-BW){gammaBuf[l*BW+BW-1]}}, gammaBuf[l*BW +: BW]};
  end

  for (genvar s = 0; s < NS; s++) begin : g_acs
    localparam int SUCC0 = bmsPkg::nextState(s, 0);
    localparam int SUCC1 = bmsPkg::nextState(s, 1);
    localparam int LAB0  = bmsPkg::branchLabel(s, 0);
    localparam int LAB1  = bmsPkg::branchLabel(s, 1);
    bmsAcs #(.W(W)) acs_i (
      .metricA (betaIn[SUCC0*W +: W]),
      .metricB (betaIn[SUCC1*W +: W]),
      .gammaA  (gammaExt[LAB0*W +: W]),
      .gammaB  (gammaExt[LAB1*W +: W]),
      .normRef (betaIn[0 +: W]),
      .result  (acsOut[s*W +: W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   betaOut <= '0;
    else if (en) betaOut <= acsOut;
  end
endmodule

// File: rtl/bmsDatapath.sv
module bmsDatapath #(
  parameter int NSTAGES = 31,
  parameter int W       = 12,
  parameter int BW      = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  bmsPkg::bmsStrobes_t                    strobes,
  input  logic [NSTAGES-1:0]                     stageEn,
  input  logic [bmsPkg::NUM_STATES*W-1:0]        betaBoundary,
  input  logic [NSTAGES*bmsPkg::NUM_LABELS*BW-1:0] gammaBus,
  output logic [bmsPkg::NUM_STATES*W-1:0]        betaOut
);
  localparam int VW = bmsPkg::NUM_STATES * W;
  localparam int GW = bmsPkg::NUM_LABELS * BW;

  logic [VW-1:0] link [NSTAGES+1];
  logic [VW-1:0] entryBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               entryBank <= '0;
    else if (strobes.loadIn) entryBank <= strobes.zeroStart ? '0 : betaBoundary;
  end

  assign link[0] = entryBank;

  for (genvar j = 0; j < NSTAGES; j++) begin : g_stage
    bmsStage #(.W(W), .BW(BW)) stage_i (
      .clk     (clk),
      .rstN    (rstN),
      .en      (stageEn[j]),
      .gammaIn (gammaBus[j*GW +: GW]),
      .betaIn  (link[j]),
      .betaOut (link[j+1])
    );
  end

  assign betaOut = link[NSTAGES];
endmodule

// File: rtl/bmsControl.sv
module bmsControl #(
  parameter int NSTAGES = 31
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                boundaryKnown,
  output bmsPkg::bmsStrobes_t strobes,
  output logic [NSTAGES-1:0]  stageEn,
  output logic                outValid
);
  logic [NSTAGES:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[NSTAGES-1:0], inValid};
  end

  assign strobes.loadIn    = inValid;
  assign strobes.zeroStart = ~boundaryKnown;
  assign stageEn           = vPipe[NSTAGES-1:0];
  assign outValid          = vPipe[NSTAGES];
endmodule

// File: rtl/bmsChain.sv
module bmsChain #(
  parameter int NSTAGES = 31,
  parameter int W       = 12,
  parameter int BW      = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic                          boundaryKnown,
  input  logic [8*W-1:0]                betaBoundary,
  input  logic [NSTAGES*4*BW-1:0]       gammaBus,
  output logic                          outValid,
  output logic [8*W-1:0]                betaOut
);
  bmsPkg::bmsStrobes_t strobes;
  logic [NSTAGES-1:0]  stageEn;

  bmsControl #(.NSTAGES(NSTAGES)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .boundaryKnown (boundaryKnown),
    .strobes       (strobes),
    .stageEn       (stageEn),
    .outValid      (outValid)
  );

  bmsDatapath #(.NSTAGES(NSTAGES), .W(W), .BW(BW)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .stageEn      (stageEn),
    .betaBoundary (betaBoundary),
    .gammaBus     (gammaBus),
    .betaOut      (betaOut)
  );
endmodule

// File: rtl/bmsChain_chk.sv
module bmsChain_chk #(
  parameter int NSTAGES = 31,
  parameter int W       = 12
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           outValid,
  input logic [8*W-1:0] betaOut
);
  localparam int CW = $clog2(NSTAGES + 3) + 1;

  logic [NSTAGES:0] seenIn;
  logic [CW-1:0]    inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenIn   <= '0;
      inFlight <= '0;
    end else begin
      seenIn   <= {seenIn[NSTAGES-1:0], inValid};
      inFlight <= inFlight + CW'(inValid) - CW'(outValid);
    end
  end

  // R3
  latency_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == seenIn[NSTAGES]);

  // R5
  no_orphan_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inFlight != '0));

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= CW'(NSTAGES + 1));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(betaOut));

  // R7
  always_ff @(negedge clk) begin
    if (!rstN) reset_state_chk: assert (!outValid && betaOut == '0);
  end
endmodule

bind bmsChain bmsChain_chk #(.NSTAGES(NSTAGES), .W(W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .betaOut  (betaOut)
);

// File: tb/bmsChain_tb_top.sv
`timescale 1ns/1ps
module bmsChain_tb_top;
  localparam int N  = 31;
  localparam int W  = 12;
  localparam int BW = 8;
  localparam int S  = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rstN;
  logic                inValid;
  logic                boundaryKnown;
  logic [8*W-1:0]      betaBoundary;
  logic [N*4*BW-1:0]   gammaBus;
  logic                outValid;
  logic [8*W-1:0]      betaOut;

  bmsChain #(.NSTAGES(N), .W(W), .BW(BW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .boundaryKnown(boundaryKnown),
    .betaBoundary(betaBoundary), .gammaBus(gammaBus),
    .outValid(outValid), .betaOut(betaOut)
  );

  int nChecks = 0;
  int nFail   = 0;
  int unsigned seed = 32'h1234_5678;

  logic signed [W-1:0]  bnd   [S][8];
  logic signed [BW-1:0] gm    [S][N][4];
  bit                   slotValid [S];
  bit                   slotKnown [S];
  logic [8*W-1:0]       expOut [S];
  string                slotTag [S];

  function automatic int rnd(int lo, int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + int'((seed >> 8) % unsigned'(hi - lo + 1));
  endfunction

  // reference from R1, R2, R4, R8
  function automatic logic [8*W-1:0] model(int w);
    logic signed [W-1:0] cur [8];
    logic signed [W-1:0] nxt [8];
    logic [8*W-1:0] packed_v;
    for (int s = 0; s < 8; s++) cur[s] = slotKnown[w] ? bnd[w][s] : '0;
    for (int j = 0; j < N; j++) begin
      for (int s = 0; s < 8; s++) begin
        logic signed [W-1:0] cand [2];
        for (int u = 0; u < 2; u++) begin
          int a, p, ns;
          logic signed [W-1:0] g;
          a  = u ^ ((s >> 1) & 1) ^ ((s >> 2) & 1);
          p  = a ^ (s & 1) ^ ((s >> 2) & 1);
          ns = ((s & 3) << 1) | a;
          g  = gm[w][j][2*u + p];
          cand[u] = cur[ns] + g;
        end
        nxt[s] = ((cand[1] > cand[0]) ? cand[1] : cand[0]) - cur[0];
      end
      for (int s = 0; s < 8; s++) cur[s] = nxt[s];
    end
    for (int s = 0; s < 8; s++) packed_v[s*W +: W] = cur[s];
    return packed_v;
  endfunction

  task automatic check(bit ok, string tag, logic [8*W-1:0] act, logic [8*W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #1000000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    logic [8*W-1:0] lastOut;
    // build the slot plan
    for (int w = 0; w < S; w++) begin
      slotValid[w] = !(w == 6 || w == 7 || w == 8 || w == 15 || w == 20);
      slotKnown[w] = !(w == 3 || w == 12);
      slotTag[w]   = slotKnown[w] ? "R1 R5 R8" : "R4";
      for (int s = 0; s < 8; s++) bnd[w][s] = W'(rnd(-300, 300));
      for (int j = 0; j < N; j++)
        for (int l = 0; l < 4; l++) gm[w][j][l] = BW'(rnd(-100, 100));
    end
    // single nonzero label per stage: slot-position check
    for (int j = 0; j < N; j++)
      for (int l = 0; l < 4; l++) gm[2][j][l] = (l == (j % 4)) ? BW'(60 + j) : '0;
    slotTag[2] = "R8";
    // wrap-around extremes
    for (int s = 0; s < 8; s++) bnd[10][s] = (s == 0) ? 12'sd2047 : -12'sd2048;
    for (int j = 0; j < N; j++)
      for (int l = 0; l < 4; l++) gm[10][j][l] = (l[0]) ? 8'sd127 : -8'sd128;
    slotTag[10] = "R2";
    for (int w = 0; w < S; w++) expOut[w] = slotValid[w] ? model(w) : '0;

    rstN = 1'b0; inValid = 1'b0; boundaryKnown = 1'b0;
    betaBoundary = '0; gammaBus = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && betaOut == '0, "R7 reset", {95'b0, outValid} | betaOut, '0);
    rstN = 1'b1;
    lastOut = '0;

    for (int c = 0; c < S + N + 4; c++) begin
      @(negedge clk);
      begin
        int w;
        w = c - 1 - N;
        if (w >= 0 && w < S) begin
          if (slotValid[w]) begin
            check(outValid == 1'b1, {"R3 valid ", slotTag[w]}, {95'b0, outValid}, 1);
            check(betaOut == expOut[w], {"R3 data ", slotTag[w]}, betaOut, expOut[w]);
            lastOut = expOut[w];
          end else begin
            check(outValid == 1'b0, "R6 idle valid", {95'b0, outValid}, 0);
            check(betaOut == lastOut, "R6 hold", betaOut, lastOut);
          end
        end else if (w < 0) begin
          check(outValid == 1'b0, "R3 early", {95'b0, outValid}, 0);
        end
      end
      // drive cycle c
      if (c < S) begin
        inValid       = slotValid[c];
        boundaryKnown = slotKnown[c];
        for (int s = 0; s < 8; s++) betaBoundary[s*W +: W] = bnd[c][s];
      end else begin
        inValid = 1'b0; boundaryKnown = 1'b1;
        betaBoundary = {8{12'h5a5}};
      end
      for (int j = 0; j < N; j++) begin
        int w2;
        w2 = c - j;
        for (int l = 0; l < 4; l++)
          gammaBus[j*4*BW + l*BW +: BW] = (w2 >= 0 && w2 < S) ? gm[w2][j][l] : BW'(rnd(-128, 127));
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule